// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block stores incoming frames, one byte per cycle, into a circular receive area of a byte-wide packet memory. The area is laid out in 256-byte pages between a programmable first page and an end page (exclusive). Each stored frame takes whole pages. It starts with a four-byte descriptor: status, the page where the following frame will begin, and the stored length in little-endian order. The frame bytes follow the descriptor.

Frames arrive on a valid/ready byte stream with start and end markers. `in_ready` is high in the idle, data and discard phases. It is low while the block pads a short frame or writes the descriptor, so a sender must hold its byte until it sees ready. A transfer happens on a rising edge where both `in_valid` and `in_ready` are high. At the start of each frame the block checks whether the controller is halted or the free space is too small. If either holds, it still consumes the whole frame but writes nothing.

Frame bytes go to memory as they arrive. The descriptor is written last, once the length is known. After the descriptor is written, the current page advances to the following frame's page and a one-cycle `rx_done` pulse is raised. The host moves the boundary page as it frees memory, and can load the current page directly.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `cur_page` is 0, `mem_we` and `rx_done` are low, and `in_ready` is high.
- R2: A frame whose start byte is accepted while `cfg_halt` is high is consumed in full. It causes no memory write, no `rx_done` and no change of `cur_page`.
- R3: Free space in bytes is 256·(bnd−cur) when cur < bnd, and otherwise 256·((end−first)−(cur−bnd)). A frame that starts while this is below MAX_FRAME+4 is consumed without any write, `rx_done` or `cur_page` change.
- R4: For an accepted frame, byte k of the stored data is written to the k-th ring address after page·256+4, where page is `cur_page` at the frame start. Exactly stored+4 memory writes occur per frame, each appearing on the port one cycle after its cause.
- R5: A data write address that reaches end·256 continues at first·256.
- R6: Frames shorter than MIN_FRAME bytes are padded with zero bytes up to MIN_FRAME. `in_ready` is low during padding and descriptor writes.
- R7: Descriptor bytes 2 and 3 hold stored+4, low byte first. Here stored = max(min(frame length, MAX_FRAME), MIN_FRAME).
- R8: Descriptor byte 0 is 0x01, or 0x21 when bit 0 of the frame's first byte is 1.
- R9: Descriptor byte 1 is the next page: page + ceil((stored+8)/256), reduced by (end−first) when it is at or beyond end.
- R10: The descriptor is written after all data bytes. `rx_done` is a one-cycle pulse that coincides with the last descriptor write, and `cur_page` takes the next-page value at that moment.
- R11: Bytes beyond MAX_FRAME in a frame are consumed but not stored.
- R12: `cfg_cur_we` loads `cfg_cur_val` into `cur_page` on the next edge. An advance from a completing frame in the same cycle takes priority.
- R13: Bytes that arrive while idle without a start marker are consumed and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Stream byte |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| cfg_halt | input | 1 | Controller halted; refuse frames |
| cfg_first_pg | input | ADDR_W-8 | First page of the ring |
| cfg_end_pg | input | ADDR_W-8 | Page just past the ring |
| cfg_bnd_pg | input | ADDR_W-8 | Host boundary page |
| cfg_cur_we | input | 1 | Load current page |
| cfg_cur_val | input | ADDR_W-8 | Value to load |
| cur_page | output | ADDR_W-8 | Current write page |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_data | output | 8 | Memory write byte |
| rx_done | output | 1 | One-cycle frame-stored pulse |

## Verification
The bench builds the block with ADDR_W=12 and MAX_FRAME=600, giving a 16-page memory in which the ring spans pages 2 to 13. A full-size frame then needs three pages, which brings space refusal and wraparound within a few frames. Frames between 1 and 700 bytes also reach the truncation limit and the padding path. Random boundary positions switch between the two free-space formulas, and a directed frame that starts on the last ring page forces both data wrap and next-page reduction.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_DROP,
    ST_PAD,
    ST_HDR
  } wr_state_e;

  localparam int HDR_BYTES = 4;
  localparam logic [7:0] STAT_GOOD  = 8'h01;
  localparam logic [7:0] STAT_GROUP = 8'h20;
endpackage

// File: rtl/rx_space_check.sv
module rx_space_check #(
  parameter int PAGE_W    = 8,
  parameter int MAX_FRAME = 1514
) (
  input  logic [PAGE_W-1:0] cur_pg,
  input  logic [PAGE_W-1:0] bnd_pg,
  input  logic [PAGE_W-1:0] first_pg,
  input  logic [PAGE_W-1:0] end_pg,
  output logic              room_ok
);
  localparam int BW = PAGE_W + 9;
  localparam logic [BW-1:0] NEED = BW'(MAX_FRAME + rx_ring_pkg::HDR_BYTES);

  logic [PAGE_W:0] free_pg;
  logic [BW-1:0]   free_b;

  always_comb begin
    if (cur_pg < bnd_pg)
      free_pg = {1'b0, bnd_pg} - {1'b0, cur_pg};
    else
      free_pg = ({1'b0, end_pg} - {1'b0, first_pg}) - ({1'b0, cur_pg} - {1'b0, bnd_pg});
    free_b  = {free_pg, 8'h00};
    room_ok = (free_b >= NEED);
  end
endmodule

// File: rtl/rx_next_page.sv
module rx_next_page #(
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 12
) (
  input  logic [PAGE_W-1:0] base_pg,
  input  logic [PAGE_W-1:0] first_pg,
  input  logic [PAGE_W-1:0] end_pg,
  input  logic [LEN_W-1:0]  stored_len,
  output logic [PAGE_W-1:0] next_pg
);
  localparam int SPW = LEN_W + 1;
  localparam int PGW = SPW - 8;
  localparam int SW  = ((PAGE_W > PGW) ? PAGE_W : PGW) + 1;

  logic [SPW-1:0] span;
  logic [SW-1:0]  pages;
  logic [SW-1:0]  sum;

  always_comb begin
    // descriptor plus trailing check bytes, rounded up to whole pages
    span  = {1'b0, stored_len} + SPW'(263);
    pages = SW'(span >> 8);
    sum   = SW'(base_pg) + pages;
    if (sum >= SW'(end_pg))
      sum = sum - SW'(end_pg - first_pg);
    next_pg = PAGE_W'(sum);
  end
endmodule

// File: rtl/rx_addr_step.sv
module rx_addr_step #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] first_pg,
  input  logic [PAGE_W-1:0] end_pg,
  output logic [ADDR_W-1:0] addr_nx
);
  logic [ADDR_W:0] inc;
  logic [ADDR_W:0] lim;

  always_comb begin
    inc = {1'b0, addr} + (ADDR_W+1)'(1);
    lim = {1'b0, end_pg, 8'h00};
    if (inc == lim)
      addr_nx = {first_pg, 8'h00};
    else
      addr_nx = ADDR_W'(inc);
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MAX_FRAME = 1514,
  parameter int MIN_FRAME = 60
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [7:0]          in_data,
  input  logic                in_sop,
  input  logic                in_eop,
  input  logic                cfg_halt,
  input  logic [ADDR_W-9:0]   cfg_first_pg,
  input  logic [ADDR_W-9:0]   cfg_end_pg,
  input  logic [ADDR_W-9:0]   cfg_bnd_pg,
  input  logic                cfg_cur_we,
  input  logic [ADDR_W-9:0]   cfg_cur_val,
  output logic [ADDR_W-9:0]   cur_page,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [7:0]          mem_data,
  output logic                rx_done
);
  localparam int PAGE_W = ADDR_W - 8;
  localparam int LEN_W  = $clog2(MAX_FRAME + 1) + 1;
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_FRAME);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
  localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

  wr_state_e          st_q;
  logic [PAGE_W-1:0]  cur_q;
  logic [PAGE_W-1:0]  base_q;
  logic [ADDR_W-1:0]  wptr_q;
  logic [LEN_W-1:0]   cnt_q;
  logic               grp_q;
  logic [1:0]         hidx_q;
  logic               we_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [7:0]         data_q;
  logic               done_q;

  logic               idle_w;
  logic               room_ok;
  logic [PAGE_W-1:0]  next_pg;
  logic [ADDR_W-1:0]  wptr_nx;
  logic [ADDR_W-1:0]  first_addr;
  logic [ADDR_W-1:0]  first_nx;
  logic [LEN_W-1:0]   cnt_after;
  logic [15:0]        total_len;
  logic [7:0]         hdr_byte;
  logic               commit;

  assign idle_w     = (st_q == ST_IDLE);
  assign in_ready   = idle_w || (st_q == ST_DATA) || (st_q == ST_DROP);
  assign first_addr = {cur_q, 8'd4};
  assign cnt_after  = (cnt_q < MAX_L) ? (cnt_q + ONE_L) : cnt_q;
  assign total_len  = 16'(cnt_q) + 16'd4;
  assign commit     = (st_q == ST_HDR) && (hidx_q == 2'd3);

  rx_space_check #(.PAGE_W(PAGE_W), .MAX_FRAME(MAX_FRAME)) u_space (
    .cur_pg   (cur_q),
    .bnd_pg   (cfg_bnd_pg),
    .first_pg (cfg_first_pg),
    .end_pg   (cfg_end_pg),
    .room_ok  (room_ok)
  );

  rx_next_page #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_next (
    .base_pg    (base_q),
    .first_pg   (cfg_first_pg),
    .end_pg     (cfg_end_pg),
    .stored_len (cnt_q),
    .next_pg    (next_pg)
  );

  rx_addr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step_run (
    .addr     (wptr_q),
    .first_pg (cfg_first_pg),
    .end_pg   (cfg_end_pg),
    .addr_nx  (wptr_nx)
  );

  rx_addr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step_first (
    .addr     (first_addr),
    .first_pg (cfg_first_pg),
    .end_pg   (cfg_end_pg),
    .addr_nx  (first_nx)
  );

  always_comb begin
    unique case (hidx_q)
      2'd0:    hdr_byte = STAT_GOOD | (grp_q ? STAT_GROUP : 8'h00);
      2'd1:    hdr_byte = 8'(next_pg);
      2'd2:    hdr_byte = total_len[7:0];
      default: hdr_byte = total_len[15:8];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      base_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
      grp_q  <= 1'b0;
      hidx_q <= 2'd0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      done_q <= 1'b0;
      if (cfg_cur_we) cur_q <= cfg_cur_val;
      unique case (st_q)
        ST_IDLE: begin
          if (in_valid && in_sop) begin
            if (cfg_halt || !room_ok) begin
              st_q <= in_eop ? ST_IDLE : ST_DROP;
            end else begin
              base_q <= cur_q;
              we_q   <= 1'b1;
              addr_q <= first_addr;
              data_q <= in_data;
              wptr_q <= first_nx;
              cnt_q  <= ONE_L;
              grp_q  <= in_data[0];
              hidx_q <= 2'd0;
              if (in_eop) st_q <= (ONE_L < MIN_L) ? ST_PAD : ST_HDR;
              else        st_q <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (in_valid) begin
            if (cnt_q < MAX_L) begin
              we_q   <= 1'b1;
              addr_q <= wptr_q;
              data_q <= in_data;
              wptr_q <= wptr_nx;
              cnt_q  <= cnt_q + ONE_L;
            end
            if (in_eop) st_q <= (cnt_after < MIN_L) ? ST_PAD : ST_HDR;
          end
        end
        ST_DROP: begin
          if (in_valid && in_eop) st_q <= ST_IDLE;
        end
        ST_PAD: begin
          we_q   <= 1'b1;
          addr_q <= wptr_q;
          data_q <= 8'h00;
          wptr_q <= wptr_nx;
          cnt_q  <= cnt_q + ONE_L;
          if ((cnt_q + ONE_L) >= MIN_L) st_q <= ST_HDR;
        end
        ST_HDR: begin
          we_q   <= 1'b1;
          addr_q <= {base_q, 6'd0, hidx_q};
          data_q <= hdr_byte;
          hidx_q <= hidx_q + 2'd1;
          if (commit) begin
            cur_q  <= next_pg;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cur_page = cur_q;
  assign mem_we   = we_q;
  assign mem_addr = addr_q;
  assign mem_data = data_q;
  assign rx_done  = done_q;
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_sop,
  input logic              cfg_halt,
  input logic              cfg_cur_we,
  input logic [PAGE_W-1:0] cur_page,
  input logic              mem_we,
  input logic              rx_done,
  input logic              idle
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done); // R10

  AST_DONE_WITH_LAST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> mem_we); // R10

  AST_PAGE_MOVES_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_page) |-> (rx_done || $past(cfg_cur_we))); // R12

  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && in_valid && in_ready && in_sop && cfg_halt) |=> !mem_we); // R2

  AST_NOT_READY_IN_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> !$past(in_ready)); // R6
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_sop     (in_sop),
  .cfg_halt   (cfg_halt),
  .cfg_cur_we (cfg_cur_we),
  .cur_page   (cur_page),
  .mem_we     (mem_we),
  .rx_done    (rx_done),
  .idle       (idle_w)
);

// File: tb/tb_rx_ring_writer.sv
`timescale 1ns/1ps
module tb_rx_ring_writer;
  localparam int ADDR_W = 12;
  localparam int PAGE_W = ADDR_W - 8;
  localparam int MAXF   = 600;
  localparam int MINF   = 60;
  localparam int FIRST  = 2;
  localparam int ENDP   = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic cfg_halt = 1'b0;
  logic [PAGE_W-1:0] cfg_first_pg = PAGE_W'(FIRST);
  logic [PAGE_W-1:0] cfg_end_pg   = PAGE_W'(ENDP);
  logic [PAGE_W-1:0] cfg_bnd_pg   = PAGE_W'(FIRST);
  logic cfg_cur_we = 1'b0;
  logic [PAGE_W-1:0] cfg_cur_val = '0;
  logic [PAGE_W-1:0] cur_page;
  logic mem_we, rx_done;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_data;

  always #2.5 clk = ~clk;

  rx_ring_writer #(.ADDR_W(ADDR_W), .MAX_FRAME(MAXF), .MIN_FRAME(MINF)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .cfg_halt(cfg_halt),
    .cfg_first_pg(cfg_first_pg), .cfg_end_pg(cfg_end_pg), .cfg_bnd_pg(cfg_bnd_pg),
    .cfg_cur_we(cfg_cur_we), .cfg_cur_val(cfg_cur_val), .cur_page(cur_page),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .rx_done(rx_done)
  );

  logic [7:0] mem_m [0:(1<<ADDR_W)-1];
  int wr_cnt = 0;
  int done_cnt = 0;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int m_cur = 0;
  logic [7:0] fr [0:799];

  always @(posedge clk) begin
    if (mem_we) begin
      mem_m[mem_addr] <= mem_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (rx_done) done_cnt <= done_cnt + 1;
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL R10 watchdog expired actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int free_bytes(int c, int b);
    if (c < b) return (b - c) * 256;
    return ((ENDP - FIRST) - (c - b)) * 256;
  endfunction

  function automatic int stored_of(int len);
    int s;
    s = (len > MAXF) ? MAXF : len;
    return (s < MINF) ? MINF : s;
  endfunction

  function automatic int next_of(int c, int stored);
    int n;
    n = c + (stored + 8 + 255) / 256;
    if (n >= ENDP) n = n - (ENDP - FIRST);
    return n;
  endfunction

  function automatic int step_of(int a);
    if (a + 1 == ENDP * 256) return FIRST * 256;
    return a + 1;
  endfunction

  task automatic send(input int len);
    for (int i = 0; i < len; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1; in_data = fr[i];
      in_sop = (i == 0); in_eop = (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic run_frame(input int len, input bit grp, input string tag);
    int w0, d0, c0, stored, nxt, a, bad_k, bad_a, bad_e;
    bit accept;
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom_range(0, 255));
    fr[0][0] = grp;
    accept = !cfg_halt && (free_bytes(m_cur, int'(cfg_bnd_pg)) >= MAXF + 4);
    w0 = wr_cnt; d0 = done_cnt; c0 = int'(cur_page);
    send(len);
    if (!accept) begin
      repeat (4) @(negedge clk);
      chk(wr_cnt == w0, {tag, " refused frame writes"}, wr_cnt - w0, 0);
      chk(done_cnt == d0 && int'(cur_page) == c0, {tag, " refused frame page"}, int'(cur_page), c0);
      return;
    end
    for (int t = 0; t < 200 && done_cnt == d0; t++) @(negedge clk);
    @(negedge clk);
    stored = stored_of(len);
    nxt = next_of(m_cur, stored);
    chk(done_cnt == d0 + 1, {tag, " R10 done pulse"}, done_cnt - d0, 1);
    chk(wr_cnt - w0 == stored + 4, {tag, " R4 write count"}, wr_cnt - w0, stored + 4);
    chk(int'(cur_page) == nxt, {tag, " R10 cur_page advance"}, int'(cur_page), nxt);
    chk(int'(mem_m[m_cur*256+1]) == nxt, {tag, " R9 next page byte"}, int'(mem_m[m_cur*256+1]), nxt);
    chk(int'(mem_m[m_cur*256+0]) == (grp ? 33 : 1), {tag, " R8 status byte"},
        int'(mem_m[m_cur*256+0]), grp ? 33 : 1);
    chk(int'({mem_m[m_cur*256+3], mem_m[m_cur*256+2]}) == stored + 4, {tag, " R7 length field"},
        int'({mem_m[m_cur*256+3], mem_m[m_cur*256+2]}), stored + 4);
    a = m_cur * 256 + 4; bad_k = -1; bad_a = 0; bad_e = 0;
    for (int k = 0; k < stored; k++) begin
      int e;
      e = (k < len) ? int'(fr[k]) : 0;
      if (bad_k < 0 && int'(mem_m[a]) != e) begin bad_k = k; bad_a = int'(mem_m[a]); bad_e = e; end
      a = step_of(a);
    end
    chk(bad_k < 0, {tag, " R4 R5 R6 R11 payload byte"}, bad_a, bad_e);
    m_cur = nxt;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(cur_page == '0 && !mem_we && !rx_done, "R1 reset outputs", int'(cur_page), 0);
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    cfg_cur_val = PAGE_W'(FIRST); cfg_cur_we = 1'b1;
    @(negedge clk); cfg_cur_we = 1'b0;
    chk(int'(cur_page) == FIRST, "R12 page load", int'(cur_page), FIRST);
    m_cur = FIRST;

    run_frame(10, 1'b0, "R6 short");
    run_frame(100, 1'b1, "R8 group");
    run_frame(650, 1'b0, "R11 long");

    cfg_halt = 1'b1;
    run_frame(80, 1'b0, "R2 halted");
    cfg_halt = 1'b0;

    begin
      int w0;
      w0 = wr_cnt;
      in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b0; in_data = 8'h5a;
      @(negedge clk); in_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(wr_cnt == w0 && int'(cur_page) == m_cur, "R13 stray byte ignored", wr_cnt - w0, 0);
    end

    cfg_bnd_pg = PAGE_W'(m_cur + 2 >= ENDP ? m_cur + 2 - (ENDP - FIRST) : m_cur + 2);
    run_frame(70, 1'b0, "R3 low space");

    cfg_cur_val = PAGE_W'(ENDP - 1); cfg_cur_we = 1'b1;
    @(negedge clk); cfg_cur_we = 1'b0;
    m_cur = ENDP - 1;
    cfg_bnd_pg = PAGE_W'(ENDP - 1);
    run_frame(600, 1'b0, "R5 wrap");

    for (int n = 0; n < 40; n++) begin
      if ($urandom_range(0, 9) < 7) cfg_bnd_pg = PAGE_W'(m_cur);
      else cfg_bnd_pg = PAGE_W'($urandom_range(FIRST, ENDP - 1));
      run_frame($urandom_range(1, 700), 1'($urandom_range(0, 1)), "R3 R9 random");
    end

    finish_run();
  end
endmodule